// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the entry into an interrupt handler for a 32-bit core that has a user mode and a kernel mode. An external request comes with an 8-bit vector and is accepted only when the core's interrupt-enable bit is set. Once a request is accepted, the block latches a snapshot of the core context. That snapshot holds the status word, the PC, the mode, the stack pointer, the saved kernel stack pointer and the vector-table base. The block then steps through a fixed sequence of register-update strobes.

The sequence has four steps:
- It drops the core into kernel mode first.
- It writes the rotated status word, the exception return address, the exception status and the cleared exception data address. If the core came from user mode, it also swaps the stack pointers.
- It issues a single word read of the handler address from the vector table.
- It loads that handler address into the PC.

A failed table read ends the sequence without a PC load and raises an access-error flag with the address that failed. Every entry ends with a one-cycle completion pulse that says whether the handler was taken.

Top module: `irq_entry_seq`

## Requirements
- R1: While `ie_i` is low, a request has no effect: `busy_o` stays low and no strobe (`ubit_clr_o`, `ccs_we_o`, `mem_req_o`, `pc_we_o`, `done_o`) is asserted.
- R2: The status word written with `ccs_we_o` equals bits 29..10 of the result taken from old bits 19..0, with bits 9..0 and 30 zero and bit 31 copied from old bit 31, i.e. ((old << 10) & 0x3FFFFFFF) | (old & 0x80000000).
- R3: `ubit_clr_o` pulses in the first cycle after acceptance, and all other register strobes come in the following cycle, never together with it.
- R4: If `user_i` was high at acceptance, `usp_we_o` writes the old stack pointer and `sp_we_o` writes the kernel stack pointer, both in the register-write cycle; from kernel mode neither strobe fires.
- R5: `erp_we_o` writes the PC captured at acceptance.
- R6: `exs_we_o` writes vector × 256, and `eda_we_o` writes 0.
- R7: `mem_req_o` pulses once, in the register-write cycle, with `mem_addr_o` = base + 4 × vector (modulo 2^32). In `mem_rdata_i`, byte lane k (bits 8k+7..8k) holds the byte at address + k, so the handler address is the little-endian word.
- R8: The cycle after `mem_valid_i` is seen, `pc_we_o` pulses with `pc_o` equal to the fetched word, and the next cycle brings the completion.
- R9: If `mem_err_i` is seen instead, no `pc_we_o` is issued; in the next cycle `done_o` pulses with `taken_o` low and `fault_o` high, and `fault_addr_o` equals the table address.
- R10: `busy_o` is high from the cycle after acceptance through the completion cycle, then low; requests made while busy are not accepted and do not alter the entry in progress.
- R11: `done_o` lasts exactly one cycle, and `taken_o` is high with it only when the PC was loaded.
- R12: After reset, and after a reset in the middle of a sequence, `busy_o` and every strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 1 | Interrupt request |
| irq_vec_i | input | 8 | Interrupt vector |
| ie_i | input | 1 | Interrupt-enable bit of the core |
| ccs_i | input | 32 | Current status word |
| pc_i | input | 32 | Current PC |
| user_i | input | 1 | Core is in user mode |
| sp_i | input | 32 | Current stack pointer |
| ksp_i | input | 32 | Saved kernel stack pointer |
| ebp_i | input | 32 | Vector-table base |
| busy_o | output | 1 | Entry sequence in progress |
| ubit_clr_o | output | 1 | Clear user-mode bit |
| ccs_we_o | output | 1 | Status word write strobe |
| ccs_o | output | 32 | New status word |
| usp_we_o | output | 1 | User-SP save strobe |
| usp_o | output | 32 | Value for user-SP register |
| sp_we_o | output | 1 | Stack pointer write strobe |
| sp_o | output | 32 | New stack pointer |
| erp_we_o | output | 1 | Exception return register write strobe |
| erp_o | output | 32 | Return address |
| exs_we_o | output | 1 | Exception status write strobe |
| exs_o | output | 32 | Exception status value |
| eda_we_o | output | 1 | Exception data address write strobe |
| eda_o | output | 32 | Exception data address value (zero) |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 32 | Table read address |
| mem_rdata_i | input | 32 | Read data, lane k = byte at address + k |
| mem_valid_i | input | 1 | Read data valid |
| mem_err_i | input | 1 | Read hit unmapped memory |
| pc_we_o | output | 1 | PC load strobe |
| pc_o | output | 32 | Handler address |
| done_o | output | 1 | Completion pulse |
| taken_o | output | 1 | Handler entered (with done_o) |
| fault_o | output | 1 | Access error (with done_o) |
| fault_addr_o | output | 32 | Failing table address |

## Verification
The timing is counted from the clock edge where the request is accepted. `ubit_clr_o` is due one cycle later. All the register strobes and `mem_req_o` are due two cycles later. After `mem_valid_i` is sampled, `pc_we_o` follows one cycle later and `done_o` two cycles later. After `mem_err_i` is sampled, `done_o` follows one cycle later, and one further cycle brings `busy_o` low. The bench drives its inputs on falling edges and samples each of these outputs on the falling edge inside the cycle it predicts. It also checks that the neighbouring cycles carry no strobe. The memory latency is stepped per vector, so the response cycle moves and the expected PC-load cycle moves with it.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UPDATE_REGS,
    ST_READ_REQ,
    ST_WAIT_DATA,
    ST_LOAD_PC,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/irq_ccs_xform.sv
module irq_ccs_xform #(
  parameter int W        = 32,
  parameter int SHIFT    = 10,
  parameter int FIELD_W  = 30,
  parameter int KEEP_BIT = 31
) (
  input  logic [W-1:0] ccs_i,
  output logic [W-1:0] ccs_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b == KEEP_BIT) begin : g_keep
      assign ccs_o[b] = ccs_i[b];
    end else if (b >= SHIFT && b < FIELD_W) begin : g_shift
      assign ccs_o[b] = ccs_i[b-SHIFT];
    end else begin : g_zero
      assign ccs_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_entry_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic       mem_valid_i,
  input  logic       mem_err_i,
  output seq_state_e state_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:        if (accept_i) state_d = ST_UPDATE_REGS;
      ST_UPDATE_REGS: state_d = ST_READ_REQ;
      ST_READ_REQ:    state_d = ST_WAIT_DATA;
      ST_WAIT_DATA: begin
        if (mem_valid_i)    state_d = ST_LOAD_PC;
        else if (mem_err_i) state_d = ST_DONE;
      end
      ST_LOAD_PC:     state_d = ST_DONE;
      ST_DONE:        state_d = ST_IDLE;
      default:        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/irq_ctx_regs.sv
module irq_ctx_regs #(
  parameter int XLEN  = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [XLEN-1:0]  ccs_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic             user_i,
  input  logic [XLEN-1:0]  sp_i,
  input  logic [XLEN-1:0]  ksp_i,
  input  logic [XLEN-1:0]  ebp_i,
  input  logic             hload_i,
  input  logic [XLEN-1:0]  hdata_i,
  output logic [VEC_W-1:0] vec_o,
  output logic [XLEN-1:0]  ccs_o,
  output logic [XLEN-1:0]  pc_o,
  output logic             user_o,
  output logic [XLEN-1:0]  sp_o,
  output logic [XLEN-1:0]  ksp_o,
  output logic [XLEN-1:0]  ebp_o,
  output logic [XLEN-1:0]  handler_o,
  output logic             loaded_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o  <= '0;
      ccs_o  <= '0;
      pc_o   <= '0;
      user_o <= 1'b0;
      sp_o   <= '0;
      ksp_o  <= '0;
      ebp_o  <= '0;
    end else if (capture_i) begin
      vec_o  <= vec_i;
      ccs_o  <= ccs_i;
      pc_o   <= pc_i;
      user_o <= user_i;
      sp_o   <= sp_i;
      ksp_o  <= ksp_i;
      ebp_o  <= ebp_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      handler_o <= '0;
      loaded_o  <= 1'b0;
    end else if (capture_i) begin
      loaded_o  <= 1'b0;
    end else if (hload_i) begin
      handler_o <= hdata_i;
      loaded_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int VEC_W    = 8,
  parameter int CCS_SH   = 10,
  parameter int CCS_FLD  = 30,
  parameter int CCS_KEEP = 31,
  parameter int EXS_SH   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_req_i,
  input  logic [VEC_W-1:0] irq_vec_i,
  input  logic             ie_i,
  input  logic [XLEN-1:0]  ccs_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic             user_i,
  input  logic [XLEN-1:0]  sp_i,
  input  logic [XLEN-1:0]  ksp_i,
  input  logic [XLEN-1:0]  ebp_i,
  output logic             busy_o,
  output logic             ubit_clr_o,
  output logic             ccs_we_o,
  output logic [XLEN-1:0]  ccs_o,
  output logic             usp_we_o,
  output logic [XLEN-1:0]  usp_o,
  output logic             sp_we_o,
  output logic [XLEN-1:0]  sp_o,
  output logic             erp_we_o,
  output logic [XLEN-1:0]  erp_o,
  output logic             exs_we_o,
  output logic [XLEN-1:0]  exs_o,
  output logic             eda_we_o,
  output logic [XLEN-1:0]  eda_o,
  output logic             mem_req_o,
  output logic [XLEN-1:0]  mem_addr_o,
  input  logic [XLEN-1:0]  mem_rdata_i,
  input  logic             mem_valid_i,
  input  logic             mem_err_i,
  output logic             pc_we_o,
  output logic [XLEN-1:0]  pc_o,
  output logic             done_o,
  output logic             taken_o,
  output logic             fault_o,
  output logic [XLEN-1:0]  fault_addr_o
);
  localparam int ENTRY_SH = $clog2(XLEN / 8);

  seq_state_e       state;
  logic             accept;
  logic             hload;
  logic [VEC_W-1:0] vec_q;
  logic [XLEN-1:0]  ccs_q, pc_q, sp_q, ksp_q, ebp_q, handler_q;
  logic             user_q, loaded_q;
  logic [XLEN-1:0]  ccs_new;
  logic             wr_phase;

  assign accept = irq_req_i && ie_i && (state == ST_IDLE);
  assign hload  = (state == ST_WAIT_DATA) && mem_valid_i;

  irq_entry_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .mem_valid_i (mem_valid_i),
    .mem_err_i   (mem_err_i),
    .state_o     (state)
  );

  irq_ctx_regs #(.XLEN(XLEN), .VEC_W(VEC_W)) u_ctx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (accept),
    .vec_i     (irq_vec_i),
    .ccs_i     (ccs_i),
    .pc_i      (pc_i),
    .user_i    (user_i),
    .sp_i      (sp_i),
    .ksp_i     (ksp_i),
    .ebp_i     (ebp_i),
    .hload_i   (hload),
    .hdata_i   (mem_rdata_i),
    .vec_o     (vec_q),
    .ccs_o     (ccs_q),
    .pc_o      (pc_q),
    .user_o    (user_q),
    .sp_o      (sp_q),
    .ksp_o     (ksp_q),
    .ebp_o     (ebp_q),
    .handler_o (handler_q),
    .loaded_o  (loaded_q)
  );

  irq_ccs_xform #(
    .W(XLEN), .SHIFT(CCS_SH), .FIELD_W(CCS_FLD), .KEEP_BIT(CCS_KEEP)
  ) u_ccs (
    .ccs_i (ccs_q),
    .ccs_o (ccs_new)
  );

  // kernel mode is forced one cycle ahead of every other write
  assign wr_phase   = (state == ST_READ_REQ);
  assign busy_o     = (state != ST_IDLE);
  assign ubit_clr_o = (state == ST_UPDATE_REGS);

  assign ccs_we_o = wr_phase;
  assign ccs_o    = ccs_new;
  assign usp_we_o = wr_phase && user_q;
  assign usp_o    = sp_q;
  assign sp_we_o  = wr_phase && user_q;
  assign sp_o     = ksp_q;
  assign erp_we_o = wr_phase;
  assign erp_o    = pc_q;
  assign exs_we_o = wr_phase;
  assign exs_o    = XLEN'(vec_q) << EXS_SH;
  assign eda_we_o = wr_phase;
  assign eda_o    = '0;

  assign mem_req_o  = wr_phase;
  assign mem_addr_o = ebp_q + (XLEN'(vec_q) << ENTRY_SH);

  assign pc_we_o      = (state == ST_LOAD_PC);
  assign pc_o         = handler_q;
  assign done_o       = (state == ST_DONE);
  assign taken_o      = done_o && loaded_q;
  assign fault_o      = done_o && !loaded_q;
  assign fault_addr_o = mem_addr_o;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ie_i,
  input logic busy_o,
  input logic ubit_clr_o,
  input logic ccs_we_o,
  input logic erp_we_o,
  input logic usp_we_o,
  input logic sp_we_o,
  input logic mem_req_o,
  input logic pc_we_o,
  input logic done_o,
  input logic taken_o,
  input logic fault_o
);
  // R1
  disabled_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !ie_i) |=> !busy_o);

  // R3
  ubit_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ubit_clr_o |=> (ccs_we_o && erp_we_o && mem_req_o && !ubit_clr_o));

  // R4
  sp_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usp_we_o |-> sp_we_o);

  // R7
  req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R8
  load_then_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |=> (done_o && taken_o));

  // R9
  fault_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (done_o && !taken_o));

  // R10
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ubit_clr_o, mem_req_o, pc_we_o, done_o}));
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ie_i       (ie_i),
  .busy_o     (busy_o),
  .ubit_clr_o (ubit_clr_o),
  .ccs_we_o   (ccs_we_o),
  .erp_we_o   (erp_we_o),
  .usp_we_o   (usp_we_o),
  .sp_we_o    (sp_we_o),
  .mem_req_o  (mem_req_o),
  .pc_we_o    (pc_we_o),
  .done_o     (done_o),
  .taken_o    (taken_o),
  .fault_o    (fault_o)
);

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        irq_req_i = 1'b0;
  logic [7:0]  irq_vec_i = '0;
  logic        ie_i = 1'b0;
  logic [31:0] ccs_i = '0, pc_i = '0, sp_i = '0, ksp_i = '0, ebp_i = '0;
  logic        user_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_valid_i = 1'b0, mem_err_i = 1'b0;
  logic        busy_o, ubit_clr_o, ccs_we_o, usp_we_o, sp_we_o, erp_we_o;
  logic        exs_we_o, eda_we_o, mem_req_o, pc_we_o, done_o, taken_o, fault_o;
  logic [31:0] ccs_o, usp_o, sp_o, erp_o, exs_o, eda_o, mem_addr_o, pc_o, fault_addr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  irq_entry_seq dut_i (.*);

  typedef struct packed {
    logic        ie;
    logic        user;
    logic        err;
    logic [2:0]  lat;
    logic [7:0]  vec;
    logic [31:0] ccs;
    logic [31:0] pc;
    logic [31:0] sp;
    logic [31:0] ksp;
    logic [31:0] ebp;
    logic [31:0] rdata;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b0, 3'd0, 8'h03, 32'h1234_5678, 32'h0000_1000, 32'h7FFF_FF00, 32'h8000_2000, 32'h0001_0000, 32'h1122_3344},
    '{1'b1, 1'b0, 1'b0, 3'd2, 8'hFF, 32'hFFFF_FFFF, 32'hDEAD_BEE0, 32'h1111_1110, 32'h2222_2220, 32'hFFFF_FC00, 32'hCAFE_F00D},
    '{1'b1, 1'b1, 1'b1, 3'd1, 8'h00, 32'h4000_0000, 32'h0000_0002, 32'h0000_0100, 32'h0000_0200, 32'h0000_8000, 32'h0},
    '{1'b1, 1'b0, 1'b0, 3'd5, 8'h80, 32'h8000_0001, 32'h0040_0000, 32'h3333_3330, 32'h4444_4440, 32'h1000_0000, 32'h0000_0001},
    '{1'b0, 1'b1, 1'b0, 3'd0, 8'h10, 32'h0000_0FFF, 32'h0000_2000, 32'h5555_5550, 32'h6666_6660, 32'h0002_0000, 32'h0},
    '{1'b1, 1'b1, 1'b1, 3'd0, 8'h41, 32'h0000_0401, 32'h0000_3004, 32'h0000_7770, 32'h0000_8880, 32'h0003_0000, 32'h0}
  };

  function automatic logic [31:0] exp_ccs(logic [31:0] c);
    return ((c << 10) & 32'h3FFF_FFFF) | (c & 32'h8000_0000);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic quiet(string req);
    chk(req, {27'b0, ubit_clr_o, ccs_we_o, mem_req_o, pc_we_o, done_o}, 32'h0);
  endtask

  task automatic run_entry(vec_t v, bit hold_req);
    logic [31:0] addr;
    addr = v.ebp + {22'b0, v.vec, 2'b00};
    @(negedge clk_i);
    irq_req_i = 1'b1; irq_vec_i = v.vec; ie_i = v.ie; ccs_i = v.ccs;
    pc_i = v.pc; user_i = v.user; sp_i = v.sp; ksp_i = v.ksp; ebp_i = v.ebp;
    @(negedge clk_i);
    irq_req_i = 1'b0;
    pc_i = ~v.pc; sp_i = ~v.sp; ccs_i = ~v.ccs;
    if (!v.ie) begin
      // R1: disabled request leaves everything idle
      chk("R1 busy", {31'b0, busy_o}, 32'h0);
      quiet("R1 strobes");
      @(negedge clk_i);
      chk("R1 busy later", {31'b0, busy_o}, 32'h0);
      quiet("R1 strobes later");
      return;
    end
    // cycle 1: kernel mode only (R3)
    chk("R10 busy after accept", {31'b0, busy_o}, 32'h1);
    chk("R3 ubit_clr", {31'b0, ubit_clr_o}, 32'h1);
    chk("R3 no early writes", {28'b0, ccs_we_o, erp_we_o, sp_we_o, mem_req_o}, 32'h0);
    @(negedge clk_i);
    // cycle 2: register writes and table read
    chk("R3 ubit one cycle", {31'b0, ubit_clr_o}, 32'h0);
    chk("R2 ccs_we", {31'b0, ccs_we_o}, 32'h1);
    chk("R2 ccs value", ccs_o, exp_ccs(v.ccs));
    chk("R4 usp_we", {31'b0, usp_we_o}, {31'b0, v.user});
    chk("R4 sp_we", {31'b0, sp_we_o}, {31'b0, v.user});
    if (v.user) begin
      chk("R4 usp value", usp_o, v.sp);
      chk("R4 sp value", sp_o, v.ksp);
    end
    chk("R5 erp", {31'b0, erp_we_o}, 32'h1);
    chk("R5 erp value", erp_o, v.pc);
    chk("R6 exs", {31'b0, exs_we_o}, 32'h1);
    chk("R6 exs value", exs_o, {16'b0, v.vec, 8'h00});
    chk("R6 eda", {eda_we_o, eda_o[30:0]}, 32'h8000_0000);
    chk("R7 mem_req", {31'b0, mem_req_o}, 32'h1);
    chk("R7 mem_addr", mem_addr_o, addr);
    @(negedge clk_i);
    chk("R7 single req", {31'b0, mem_req_o}, 32'h0);
    for (int i = 0; i < int'(v.lat); i++) begin
      if (hold_req) begin
        irq_req_i = 1'b1; irq_vec_i = 8'h55; ebp_i = 32'h0BAD_0000;
      end
      chk("R10 busy waiting", {31'b0, busy_o}, 32'h1);
      quiet("R8 quiet while waiting");
      @(negedge clk_i);
    end
    irq_req_i = 1'b0;
    mem_rdata_i = v.rdata;
    mem_valid_i = !v.err;
    mem_err_i = v.err;
    @(negedge clk_i);
    mem_valid_i = 1'b0; mem_err_i = 1'b0; mem_rdata_i = 32'hFFFF_FFFF;
    if (!v.err) begin
      chk("R8 pc_we", {31'b0, pc_we_o}, 32'h1);
      chk("R8 pc value", pc_o, v.rdata);
      chk("R11 no early done", {31'b0, done_o}, 32'h0);
      @(negedge clk_i);
      chk("R11 done taken", {29'b0, done_o, taken_o, fault_o}, 32'h6);
    end else begin
      chk("R9 no pc_we", {31'b0, pc_we_o}, 32'h0);
      chk("R9 done fault", {29'b0, done_o, taken_o, fault_o}, 32'h5);
      chk("R9 fault addr", fault_addr_o, addr);
    end
    chk("R10 busy in done", {31'b0, busy_o}, 32'h1);
    @(negedge clk_i);
    chk("R10 busy released", {31'b0, busy_o}, 32'h0);
    chk("R11 done one cycle", {31'b0, done_o}, 32'h0);
  endtask

  initial begin
    // R12: reset state
    #1;
    chk("R12 reset busy", {31'b0, busy_o}, 32'h0);
    quiet("R12 reset strobes");
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R12 idle after reset", {31'b0, busy_o}, 32'h0);

    for (int k = 0; k < NV; k++) run_entry(VECS[k], 1'b0);

    // R10: requests during an entry are not taken
    run_entry(VECS[3], 1'b1);
    @(negedge clk_i);
    chk("R10 no reentry", {31'b0, busy_o}, 32'h0);
    quiet("R10 no reentry strobes");

    // R12: reset mid-sequence
    @(negedge clk_i);
    irq_req_i = 1'b1; ie_i = 1'b1; irq_vec_i = 8'h07;
    @(negedge clk_i);
    irq_req_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R12 busy in reset", {31'b0, busy_o}, 32'h0);
    quiet("R12 strobes in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R12 idle after mid reset", {31'b0, busy_o}, 32'h0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule